// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between a synchronous host and an external 32K x 8 asynchronous static RAM. The host hands over one request per handshake: an address, a write flag and a write byte. The block turns each request into a pin-level read or write cycle on the RAM. Write bytes go into the array. A read byte comes back through a single-cycle response strobe. All RAM timing minimums are given in nanoseconds and turned into whole clock counts by a ceiling divide over the clock period, with a floor of one cycle. Changing the clock-period parameter therefore retimes every phase.

The request side is valid/ready. `req_ready` is high only while the sequencer is idle, and a request transfers on a rising edge where `req_valid` and `req_ready` are both high. The host must hold its request until that edge. While the block is busy, `req_valid` and the request fields are not looked at, so a request withdrawn before `req_ready` returns is lost. The read response has no back-pressure: `rd_valid` is high for exactly one cycle and `rd_data` is valid in that cycle.

The RAM bidirectional bus appears as three signals: a drive value, a sampled value and a drive enable. Between requests the RAM is parked in its low-power deselected state.

Top module: `sram_port_ctrl`

## Requirements
- R1: After reset, and whenever no request is in progress, the block holds `mem_cs_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `req_ready`=1.
- R2: `req_ready` is 0 from the cycle after an accepted request until that request's cycle is finished. A `req_valid` pulse during that time is not accepted and leaves the RAM contents unchanged.
- R3: A write holds `mem_we_n`=0, `mem_cs_n`=0 and `mem_ce`=1 together for exactly WP_CYC consecutive cycles. WP_CYC is the larger of ceil(20 ns / period) and the release count plus the data-setup count, which is 3 cycles at 10 ns.
- R4: `mem_addr` is stable throughout every write pulse and every read access.
- R5: `mem_dq_oe` is high only while `mem_we_n` is low. It rises no earlier than ceil(10 ns / period) cycles after `mem_we_n` falls. It stays high with a constant `mem_dq_out` for at least ceil(15 ns / period) cycles before `mem_we_n` rises.
- R6: After a write pulse, `mem_we_n` stays high for at least ceil(5 ns / period) cycles before any further fall, so a write enable is never held low across two writes. The write pulse and its recovery together span at least 25 ns.
- R7: A read holds `mem_cs_n`=0, `mem_ce`=1, `mem_we_n`=1, `mem_oe_n`=0 and `mem_dq_oe`=0 for RD_CYC cycles. RD_CYC is the larger of ceil(25 ns / period) and ceil(9 ns / period), which is 3 at 10 ns.
- R8: At the last edge of a read, the byte on `mem_dq_in` is captured. It is presented on `rd_data` with `rd_valid`=1 for exactly one cycle, so a read returns the last byte written to that address.
- R9: `mem_we_n` and `mem_oe_n` are never both low, and `mem_dq_oe` is never high while `mem_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request can transfer |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Byte to store on a write |
| rd_valid | output | 1 | One-cycle read response strobe |
| rd_data | output | 8 | Byte returned by a read |
| mem_addr | output | 15 | RAM address pins |
| mem_dq_out | output | 8 | Value driven onto the RAM data bus |
| mem_dq_in | input | 8 | Value seen on the RAM data bus |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_ce | output | 1 | RAM enable, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |

## Verification
On every cycle, the assertions check the relative ordering of the pin controls: pulse widths, recovery gaps, the bus release and setup windows, address stability, and the exclusion between write strobe and output enable. What they cannot show is whether a stored byte comes back intact or whether a busy-time request is truly dropped. A behavioural RAM model in the bench covers this. It times each control in nanoseconds, returns garbage until the access time has elapsed, and is compared against a reference copy over random and directed addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WPULSE = 2'd1,
    ST_WRECOV = 2'd2,
    ST_READ   = 2'd3
  } seq_state_t;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          zero
);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW      = 2,
  parameter int unsigned WP_LOAD = 2,
  parameter int unsigned WR_LOAD = 0,
  parameter int unsigned RD_LOAD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          fire_write,
  input  logic          zero,
  output seq_state_t    state,
  output logic          load,
  output logic [CW-1:0] load_val
);

  seq_state_t nxt;

  always_comb begin
    nxt      = state;
    load     = 1'b0;
    load_val = '0;
    unique case (state)
      ST_IDLE: begin
        if (fire) begin
          load = 1'b1;
          if (fire_write) begin
            nxt      = ST_WPULSE;
            load_val = CW'(WP_LOAD);
          end else begin
            nxt      = ST_READ;
            load_val = CW'(RD_LOAD);
          end
        end
      end
      ST_WPULSE: begin
        if (zero) begin
          nxt      = ST_WRECOV;
          load     = 1'b1;
          load_val = CW'(WR_LOAD);
        end
      end
      ST_WRECOV: if (zero) nxt = ST_IDLE;
      ST_READ:   if (zero) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/sram_ctrl_pins.sv
module sram_ctrl_pins
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CW        = 2,
  parameter int unsigned DRIVE_LIM = 2
) (
  input  seq_state_t    state,
  input  logic [CW-1:0] cnt,
  output logic          cs_n,
  output logic          ce,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);

  always_comb begin
    cs_n  = 1'b1;
    ce    = 1'b0;
    we_n  = 1'b1;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    unique case (state)
      ST_WPULSE: begin
        cs_n  = 1'b0;
        ce    = 1'b1;
        we_n  = 1'b0;
        // bus turned on only after the RAM has let go of it
        dq_oe = (int'(cnt) < int'(DRIVE_LIM));
      end
      ST_WRECOV: begin
        cs_n = 1'b0;
        ce   = 1'b1;
      end
      ST_READ: begin
        cs_n = 1'b0;
        ce   = 1'b1;
        oe_n = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sram_port_ctrl.sv
module sram_port_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned WPULSE_NS     = 20,
  parameter int unsigned WGAP_NS       = 5,
  parameter int unsigned WCYCLE_NS     = 25,
  parameter int unsigned WDSETUP_NS    = 15,
  parameter int unsigned WRELEASE_NS   = 10,
  parameter int unsigned RACCESS_NS    = 25,
  parameter int unsigned ROE_NS        = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe,
  output logic              mem_cs_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n
);

  localparam int unsigned WZ_CYC  = ns2cyc(WRELEASE_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_CYC  = ns2cyc(WDSETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned WP_CYC  = umax(ns2cyc(WPULSE_NS, CLK_PERIOD_NS), WZ_CYC + DS_CYC);
  localparam int unsigned WC_CYC  = ns2cyc(WCYCLE_NS, CLK_PERIOD_NS);
  localparam int unsigned WR_CYC  = umax(ns2cyc(WGAP_NS, CLK_PERIOD_NS),
                                         (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1);
  localparam int unsigned RD_CYC  = umax(ns2cyc(RACCESS_NS, CLK_PERIOD_NS),
                                         ns2cyc(ROE_NS, CLK_PERIOD_NS));
  localparam int unsigned MAX_CYC = umax(WP_CYC, umax(WR_CYC, RD_CYC));
  localparam int unsigned CW      = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  seq_state_t    state;
  logic          fire, tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val, tmr_cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign req_ready = (state == ST_IDLE);
  assign fire      = req_valid && req_ready;

  sram_ctrl_seq #(
    .CW(CW), .WP_LOAD(WP_CYC - 1), .WR_LOAD(WR_CYC - 1), .RD_LOAD(RD_CYC - 1)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_write(req_write),
    .zero(tmr_zero), .state(state), .load(tmr_load), .load_val(tmr_val)
  );

  sram_ctrl_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .cnt(tmr_cnt), .zero(tmr_zero)
  );

  sram_ctrl_pins #(.CW(CW), .DRIVE_LIM(WP_CYC - WZ_CYC)) u_pins (
    .state(state), .cnt(tmr_cnt), .cs_n(mem_cs_n), .ce(mem_ce),
    .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  // request fields held for the whole RAM cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      addr_q <= req_addr;
      data_q <= req_wdata;
    end
  end

  assign mem_addr   = addr_q;
  assign mem_dq_out = data_q;

  // sample the bus at the closing edge of the access window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= (state == ST_READ) && tmr_zero;
      if ((state == ST_READ) && tmr_zero) rd_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 15,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned WPULSE_NS     = 20,
  parameter int unsigned WGAP_NS       = 5,
  parameter int unsigned WDSETUP_NS    = 15,
  parameter int unsigned WRELEASE_NS   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe,
  input logic              mem_cs_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n
);

  localparam int unsigned WP_MIN = ns2cyc(WPULSE_NS, CLK_PERIOD_NS);
  localparam int unsigned WR_MIN = ns2cyc(WGAP_NS, CLK_PERIOD_NS);
  localparam int unsigned DS_MIN = ns2cyc(WDSETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned WZ_MIN = ns2cyc(WRELEASE_NS, CLK_PERIOD_NS);

  // run lengths of earlier samples, saturating
  logic [7:0] lo_run, hi_run, drv_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_run  <= '0;
      hi_run  <= 8'hFF;
      drv_run <= '0;
    end else begin
      lo_run  <= mem_we_n ? 8'd0 : ((lo_run == 8'hFF) ? lo_run : lo_run + 8'd1);
      hi_run  <= !mem_we_n ? 8'd0 : ((hi_run == 8'hFF) ? hi_run : hi_run + 8'd1);
      drv_run <= !mem_dq_oe ? 8'd0 : ((drv_run == 8'hFF) ? drv_run : drv_run + 8'd1);
    end
  end

  // R1
  idle_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R3
  wpulse_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_ce));

  // R3
  wpulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(lo_run) >= int'(WP_MIN)));

  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  // R4
  raddr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && $past(!mem_oe_n)) |-> $stable(mem_addr));

  // R5
  drive_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  // R5
  drive_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (int'(lo_run) >= int'(WZ_MIN)));

  // R5
  drive_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (int'(drv_run) >= int'(DS_MIN)));

  // R5
  drive_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  // R6
  wgap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (int'(hi_run) >= int'(WR_MIN)));

  // R8
  resp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n));

  // R9
  no_we_oe_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  // R9
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

endmodule

bind sram_port_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .WPULSE_NS(WPULSE_NS), .WGAP_NS(WGAP_NS), .WDSETUP_NS(WDSETUP_NS),
  .WRELEASE_NS(WRELEASE_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
  .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
  .mem_cs_n(mem_cs_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
);

// File: tb/tb_sram_port_ctrl.sv
module tb_sram_port_ctrl;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [14:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'h5A;
  logic        mem_dq_oe, mem_cs_n, mem_ce, mem_we_n, mem_oe_n;

  always #(CLK_NS/2) clk = ~clk;

  sram_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe),
    .mem_cs_n(mem_cs_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural RAM model, timed in ns ----------------
  logic [7:0] ram [int];
  logic [7:0] refm [int];
  int viol_r4 = 0, viol_r5 = 0, viol_r6 = 0, viol_r3 = 0, both_low = 0;
  bit wr_act = 0;
  int lo_n = 0, drv_n = 0, hi_n = 1000, rd_age = 0;
  logic [14:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  bit prev_rd = 0;
  int last_wp = 0, last_gap = 1000, min_gap = 1000, last_rd = 0, oe_run = 0;

  function automatic logic [7:0] ram_get(input logic [14:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 8'h00;
  endfunction
  function automatic logic [7:0] ref_get(input logic [14:0] a);
    return refm.exists(int'(a)) ? refm[int'(a)] : 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit sel, act, rd;
      sel = !mem_cs_n && mem_ce;
      act = sel && !mem_we_n;
      rd  = sel && mem_we_n && !mem_oe_n;
      if (!mem_we_n && !mem_oe_n) both_low++;
      if (mem_dq_oe && (rd || !act)) viol_r5++;
      if (act) begin
        if (!wr_act) begin
          if (hi_n * CLK_NS < 5) viol_r6++;
          last_gap = hi_n;
          if (hi_n < min_gap) min_gap = hi_n;
          lo_n = 1; drv_n = 0; wr_addr = mem_addr;
        end else begin
          lo_n++;
          if (mem_addr != wr_addr) viol_r4++;
        end
        if (mem_dq_oe) begin
          if (drv_n == 0 && (lo_n - 1) * CLK_NS < 10) viol_r5++;
          if (drv_n > 0 && mem_dq_out != wr_data) viol_r5++;
          drv_n++;
          wr_data = mem_dq_out;
        end else if (drv_n > 0) viol_r5++;
        wr_act = 1;
      end else if (wr_act) begin
        if (lo_n * CLK_NS < 20) viol_r3++;
        if (drv_n * CLK_NS < 15) viol_r5++;
        last_wp = lo_n;
        ram[int'(wr_addr)] = wr_data;
        wr_act = 0;
        hi_n = 1;
      end else if (hi_n < 1000) hi_n++;
      // read side: garbage until access and enable times have both elapsed
      if (rd) begin
        if (prev_rd && mem_addr == rd_addr) rd_age++;
        else rd_age = 1;
        rd_addr = mem_addr;
        mem_dq_in = (rd_age * CLK_NS >= 25 && rd_age * CLK_NS >= 9) ? ram_get(mem_addr) : 8'hEE;
        oe_run++;
      end else begin
        if (prev_rd) last_rd = oe_run;
        oe_run = 0;
        mem_dq_in = 8'h5A;
      end
      prev_rd = rd;
    end
  end

  // ---------------- host tasks ----------------
  task automatic host_write(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    refm[int'(a)] = d;
  endtask

  task automatic host_read(input logic [14:0] a, output logic [7:0] q, output bit ok);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    ok = 0; q = 8'h00;
    for (int i = 0; i < 20; i++) begin
      if (rd_valid) begin q = rd_data; ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic read_check(input logic [14:0] a, input string req);
    logic [7:0] q; bit ok;
    host_read(a, q, ok);
    chk(ok, {req, " response"}, ok, 1);
    chk(q == ref_get(a), req, q, ref_get(a));
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset parking
    chk(mem_cs_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1 parked pins", {mem_cs_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(req_ready && !rd_valid, "R1 ready", {req_ready, rd_valid}, 2'b10);

    // directed corners: address extremes and data patterns
    host_write(15'h0000, 8'h00);
    host_write(15'h7FFF, 8'hFF);
    host_write(15'h1234, 8'h11);
    read_check(15'h7FFF, "R8 top address");
    read_check(15'h0000, "R8 bottom address");
    // R7 read access length
    chk(last_rd == 3, "R7 read window cycles", last_rd, 3);
    // R3 pulse length, R6 back-to-back gap
    host_write(15'h0AAA, 8'hA5);
    host_write(15'h0555, 8'h5A);
    chk(last_wp == 3, "R3 write pulse cycles", last_wp, 3);
    chk(last_gap >= 1 && last_gap * CLK_NS >= 5, "R6 gap between writes", last_gap, 1);
    chk((last_wp + last_gap) * CLK_NS >= 25, "R6 write cycle span", (last_wp + last_gap) * CLK_NS, 25);
    read_check(15'h0AAA, "R8 pattern A5");

    // R2: request offered while busy must be dropped
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 15'h2222; req_wdata = 8'h77;
    @(negedge clk);
    refm[32'h2222] = 8'h77;
    chk(!req_ready, "R2 ready low when busy", req_ready, 0);
    req_addr = 15'h1234; req_wdata = 8'h99;
    @(negedge clk);
    chk(!req_ready, "R2 ready still low", req_ready, 0);
    req_valid = 0;
    read_check(15'h1234, "R2 busy request ignored");
    read_check(15'h2222, "R2 accepted write landed");

    // R1 idle after traffic
    repeat (3) @(negedge clk);
    chk(req_ready && mem_cs_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1 idle after traffic", {req_ready, mem_cs_n, mem_ce}, 3'b110);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [14:0] a;
      a = (n % 4 == 0) ? 15'(($urandom % 8) + 15'h7FF8) : 15'($urandom);
      if (($urandom % 2) == 0) host_write(a, 8'($urandom));
      else read_check(a, "R8 random read");
    end
    foreach (refm[k]) read_check(15'(k), "R8 final sweep");

    chk(viol_r3 == 0, "R3 model pulse width", viol_r3, 0);
    chk(viol_r4 == 0, "R4 model address hold", viol_r4, 0);
    chk(viol_r5 == 0, "R5 model data drive", viol_r5, 0);
    chk(viol_r6 == 0 && min_gap >= 1, "R6 model recovery", viol_r6, 0);
    chk(both_low == 0, "R9 strobe overlap", both_low, 0);
    done = 1;
    finish_run();
  end

endmodule